// File: doc/BRIEF.md
# Power-Fail Evidence Record Committer

This block stores one fixed-length power-fail evidence record in word-wide non-volatile storage. It is built so that a supply collapse at any moment leaves the slot either fully trustworthy or plainly unusable. A sequencer presents eight payload words and pulses a request: the event tick, the sense source, the bus voltage sample, the storage-capacitor voltage sample, temperature, the hold-up entry tick, the power-path state and the load-shed mask. The committer streams the payload out one word per accepted storage handshake and folds each word into a CRC. It then writes the CRC, then a sequence number, and last a fixed validity marker. A reader after reboot trusts only slots that carry the marker and a matching CRC.

Every record goes to a new slot, and slots are used in a ring, so a record that was good before is never rewritten in place. A safe-write-voltage-low input stops the stream at once and withholds the marker. A per-word timeout stops a storage port that stalls. In both cases the half-written slot stays invalid.

Top module: `pfrec_committer`

## Requirements
- R1: Payload word k (taken from `rec_i[k*DW +: DW]`) is written at word offset k for k = 0..P-1. The CRC follows at offset P, the sequence number at offset P+1, and the marker word (default 16'hA55A) at offset P+2. The address is `{slot, offset}`, with the offset in the low `$clog2(P+3)` bits (4 bits by default).
- R2: The CRC word holds, in its low 16 bits, a CRC-16 with polynomial 0x1021, initial value 0xFFFF and no final inversion. It is computed over the payload words in write order, most significant bit first.
- R3: The first record committed after reset carries sequence number 0. The number rises by one for each committed record only; aborted or timed-out records leave it unchanged.
- R4: `flush_started_o` is high for exactly one cycle: the first cycle in which payload word 0 is on the port. `done_o` is a one-cycle pulse in the cycle after the marker word is accepted, and is raised at no other time.
- R5: Each started record, whether it completes or not, uses the slot after the previous one. Slots start at 0 after reset and wrap modulo SLOTS.
- R6: A word is transferred on a clock edge where `nvm_we_o` and `nvm_rdy_i` are both high. While ready is low, the address and data are held unchanged.
- R7: If `vlow_i` is high on an edge before the one where the marker is accepted, no further word is presented, the marker is never written, and `abort_o` pulses for one cycle.
- R8: A word presented for TMO cycles without being accepted is withdrawn. `tmo_err_o` pulses for one cycle and the marker is not written.
- R9: A request is ignored while a record is in progress or while `vlow_i` is high; it starts no write.
- R10: After reset the block is idle, with `nvm_we_o`, `busy_o`, `done_o`, `abort_o`, `tmo_err_o` and `flush_started_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a record commit |
| rec_i | input | P*DW | Payload words, word k in bits k*DW upward |
| vlow_i | input | 1 | Safe-write voltage is low |
| busy_o | output | 1 | A record is in progress |
| flush_started_o | output | 1 | One-cycle pulse when the first word goes out |
| done_o | output | 1 | One-cycle pulse after the marker is accepted |
| abort_o | output | 1 | One-cycle pulse on a low-voltage abort |
| tmo_err_o | output | 1 | One-cycle pulse on a storage write timeout |
| nvm_we_o | output | 1 | Storage write request |
| nvm_addr_o | output | AW | Storage word address {slot, offset} |
| nvm_wdata_o | output | DW | Storage write data |
| nvm_rdy_i | input | 1 | Storage accepts the word at this edge |

## Verification
The sharpest case is a low-voltage event that arrives while the marker word is stalled on a not-ready port. A design that let the marker through would leave a slot that looks valid but was cut short. A timeout that kept going would also write a marker into an unfinished slot, and a CRC that missed the last payload word would fail every readback. Randomly stalled ready signals test that words are held stable and stay in order. Repeated records across aborts and timeouts show whether the sequence number wrongly advances on a failed record, or whether a slot is reused in place instead of the ring moving on.

// File: rtl/pfrec_pkg.sv
package pfrec_pkg;
  typedef enum logic {CS_IDLE, CS_WRITE} cstate_e;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
endpackage

// File: rtl/pfrec_crc.sv
module pfrec_crc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [15:0]   crc_q,
  output logic [15:0]   crc_nxt
);
  import pfrec_pkg::*;

  // bit-serial fold of one full word, MSB first
  always_comb begin
    logic [15:0] c;
    logic        fb;
    c = crc_q;
    for (int b = DW - 1; b >= 0; b--) begin
      fb = c[15] ^ din[b];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    crc_nxt = c;
  end

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= CRC_SEED;
    else if (init) crc_q <= CRC_SEED;
    else if (en)   crc_q <= crc_nxt;
  end
endmodule

// File: rtl/pfrec_ledger.sv
module pfrec_ledger #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              commit,
  output logic [SLOT_W-1:0] slot_cur,
  output logic [DW-1:0]     seq_q
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_nxt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_nxt_q <= '0;
      slot_cur   <= '0;
    end else if (start) begin
      slot_cur   <= slot_nxt_q;
      slot_nxt_q <= (slot_nxt_q == LAST_SLOT) ? '0 : slot_nxt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         seq_q <= '0;
    else if (commit) seq_q <= seq_q + 1'b1;
  end
endmodule

// File: rtl/pfrec_wdog.sv
module pfrec_wdog #(
  parameter int TMO = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic stall,
  output logic expire
);
  localparam int CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TMO - 1);

  logic [CW-1:0] cnt_q;

  assign expire = stall && (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (stall)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pfrec_committer.sv
module pfrec_committer #(
  parameter int          DW        = 16,
  parameter int          P         = 8,
  parameter int          SLOTS     = 4,
  parameter int          TMO       = 16,
  parameter logic [15:0] MARK_WORD = 16'hA55A,
  parameter int          OFF_W     = $clog2(P + 3),
  parameter int          SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  parameter int          AW        = SLOT_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic [P*DW-1:0] rec_i,
  input  logic            vlow_i,
  output logic            busy_o,
  output logic            flush_started_o,
  output logic            done_o,
  output logic            abort_o,
  output logic            tmo_err_o,
  output logic            nvm_we_o,
  output logic [AW-1:0]   nvm_addr_o,
  output logic [DW-1:0]   nvm_wdata_o,
  input  logic            nvm_rdy_i
);
  import pfrec_pkg::*;

  localparam logic [OFF_W-1:0] CRC_OFF = OFF_W'(P);
  localparam logic [OFF_W-1:0] SEQ_OFF = OFF_W'(P + 1);
  localparam logic [OFF_W-1:0] MRK_OFF = OFF_W'(P + 2);

  cstate_e           st_q;
  logic [DW-1:0]     pbuf [P];
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  off_inc;
  logic              we_q;
  logic [DW-1:0]     wd_q;
  logic              fs_q, done_q, ab_q, er_q;
  logic [SLOT_W-1:0] slot_cur;
  logic [DW-1:0]     seq_q;
  logic [15:0]       crc_q, crc_nxt;
  logic [DW-1:0]     word_nxt;
  logic              xfer, mark_xfer, start, commit, abort_now, tmo_hit;

  assign xfer      = we_q && nvm_rdy_i;
  assign mark_xfer = xfer && (off_q == MRK_OFF);
  assign start     = (st_q == CS_IDLE) && req_i && !vlow_i;
  assign commit    = (st_q == CS_WRITE) && mark_xfer;
  assign abort_now = (st_q == CS_WRITE) && !mark_xfer && vlow_i;
  assign off_inc   = off_q + 1'b1;

  pfrec_crc #(.DW(DW)) u_crc (
    .clk     (clk),
    .rst     (rst),
    .init    (start),
    .en      (xfer && (off_q < CRC_OFF)),
    .din     (wd_q),
    .crc_q   (crc_q),
    .crc_nxt (crc_nxt)
  );

  pfrec_ledger #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .DW(DW)) u_ledger (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .commit   (commit),
    .slot_cur (slot_cur),
    .seq_q    (seq_q)
  );

  pfrec_wdog #(.TMO(TMO)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .clear  (!we_q || xfer),
    .stall  (we_q && !nvm_rdy_i),
    .expire (tmo_hit)
  );

  // payload capture; plain register array without reset
  always_ff @(posedge clk) begin
    if (start) begin
      for (int k = 0; k < P; k++) pbuf[k] <= rec_i[k*DW +: DW];
    end
  end

  // data for the word that follows the one now being accepted
  always_comb begin
    word_nxt = '0;
    for (int k = 0; k < P; k++) begin
      if (off_inc == OFF_W'(k)) word_nxt = pbuf[k];
    end
    if (off_inc == CRC_OFF) word_nxt = DW'(crc_nxt);
    if (off_inc == SEQ_OFF) word_nxt = seq_q;
    if (off_inc == MRK_OFF) word_nxt = DW'(MARK_WORD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CS_IDLE;
      off_q  <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      fs_q   <= 1'b0;
      done_q <= 1'b0;
      ab_q   <= 1'b0;
      er_q   <= 1'b0;
    end else begin
      fs_q   <= 1'b0;
      done_q <= 1'b0;
      ab_q   <= 1'b0;
      er_q   <= 1'b0;
      case (st_q)
        CS_IDLE: begin
          if (start) begin
            st_q  <= CS_WRITE;
            off_q <= '0;
            we_q  <= 1'b1;
            wd_q  <= rec_i[DW-1:0];
            fs_q  <= 1'b1;
          end
        end
        CS_WRITE: begin
          if (commit) begin
            st_q   <= CS_IDLE;
            we_q   <= 1'b0;
            done_q <= 1'b1;
          end else if (abort_now) begin
            st_q <= CS_IDLE;
            we_q <= 1'b0;
            ab_q <= 1'b1;
          end else if (xfer) begin
            off_q <= off_inc;
            wd_q  <= word_nxt;
          end else if (tmo_hit) begin
            st_q <= CS_IDLE;
            we_q <= 1'b0;
            er_q <= 1'b1;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign busy_o          = (st_q == CS_WRITE);
  assign flush_started_o = fs_q;
  assign done_o          = done_q;
  assign abort_o         = ab_q;
  assign tmo_err_o       = er_q;
  assign nvm_we_o        = we_q;
  assign nvm_addr_o      = {slot_cur, off_q};
  assign nvm_wdata_o     = wd_q;
endmodule

// File: rtl/pfrec_sva.sv
module pfrec_sva #(
  parameter int DW      = 16,
  parameter int AW      = 6,
  parameter int OFF_W   = 4,
  parameter int MRK_OFF = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          flush_started_o,
  input logic          done_o,
  input logic          abort_o,
  input logic          tmo_err_o,
  input logic          vlow_i,
  input logic          nvm_we_o,
  input logic          nvm_rdy_i,
  input logic [AW-1:0] nvm_addr_o,
  input logic [DW-1:0] nvm_wdata_o
);
  logic [OFF_W-1:0] off;
  logic             mark_acc;
  assign off      = nvm_addr_o[OFF_W-1:0];
  assign mark_acc = nvm_we_o && nvm_rdy_i && (off == OFF_W'(MRK_OFF));

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (nvm_we_o && !nvm_rdy_i) |=> (!nvm_we_o || ($stable(nvm_addr_o) && $stable(nvm_wdata_o)))); // R6
  AST_NEXT_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (nvm_we_o && nvm_rdy_i && !mark_acc) |=> (!nvm_we_o || off == OFF_W'($past(off) + 1'b1))); // R1
  AST_DONE_AFTER_MARK: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(mark_acc)); // R4
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, abort_o, tmo_err_o})); // R7
  AST_VLOW_STOP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && vlow_i && !mark_acc) |=> !nvm_we_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !nvm_we_o); // R9
  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (rst)
    flush_started_o |-> (nvm_we_o && off == '0)); // R4
endmodule

bind pfrec_committer pfrec_sva #(.DW(DW), .AW(AW), .OFF_W(OFF_W), .MRK_OFF(P + 2)) u_sva (
  .clk             (clk),
  .rst             (rst),
  .busy_o          (busy_o),
  .flush_started_o (flush_started_o),
  .done_o          (done_o),
  .abort_o         (abort_o),
  .tmo_err_o       (tmo_err_o),
  .vlow_i          (vlow_i),
  .nvm_we_o        (nvm_we_o),
  .nvm_rdy_i       (nvm_rdy_i),
  .nvm_addr_o      (nvm_addr_o),
  .nvm_wdata_o     (nvm_wdata_o)
);

// File: tb/tb_pfrec_committer.sv
`timescale 1ns/100ps
module tb_pfrec_committer;
  localparam int DW = 16, P = 8, SLOTS = 4, TMO = 16;
  localparam int AW = 6, MRK = P + 2;
  localparam logic [15:0] MARK = 16'hA55A;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, req, vlow, rdy;
  logic [P*DW-1:0] rec;
  logic busy, fs, done, abrt, terr, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;

  pfrec_committer dut (
    .clk(clk), .rst(rst), .req_i(req), .rec_i(rec), .vlow_i(vlow),
    .busy_o(busy), .flush_started_o(fs), .done_o(done), .abort_o(abrt),
    .tmo_err_o(terr), .nvm_we_o(we), .nvm_addr_o(addr), .nvm_wdata_o(wdata),
    .nvm_rdy_i(rdy)
  );

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 2;
  int exp_seq = 0, exp_slot = 0;
  logic [AW-1:0] la [64];
  logic [DW-1:0] ld [64];
  int ln = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [P*DW-1:0] pl);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < P; k++)
      for (int b = DW - 1; b >= 0; b--)
        c = (c << 1) ^ (((c[15] ^ pl[k*DW + b]) != 1'b0) ? 16'h1021 : 16'h0000);
    return c;
  endfunction

  // ready driver: 0 random, 1 never, 2 always, 3 stall on the marker word
  initial begin
    rdy = 1'b0;
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0: rdy = ($urandom_range(0, 3) != 0);
        1: rdy = 1'b0;
        2: rdy = 1'b1;
        default: rdy = !(we && addr[3:0] == 4'(MRK));
      endcase
    end
  end

  // transfer monitor: logs the word the coming edge accepts
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && we && rdy && ln < 64) begin
        la[ln] = addr;
        ld[ln] = wdata;
        ln++;
      end
    end
  end

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // kind: 0 commit, 1 low-voltage abort, 2 timeout
  task automatic run_rec(input int kind, input int vlow_at, input bit dbl);
    logic [P*DW-1:0] pl;
    int endk = -1, we_cyc = 0, n_before;
    for (int k = 0; k < P; k++) pl[k*DW +: DW] = 16'($urandom);
    ln = 0;
    @(negedge clk);
    req = 1'b1; rec = pl;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin endk = 0; break; end
      if (abrt) begin endk = 1; break; end
      if (terr) begin endk = 2; break; end
      if (i == 0) chk(fs === 1'b1 && we === 1'b1 && addr[3:0] == 4'd0, "R4 flush start", {fs, we}, 2'b11);
      if (i == 1) chk(fs === 1'b0, "R4 flush single cycle", fs, 0);
      if (we) we_cyc++;
      if (vlow_at >= 0 && ln >= vlow_at) vlow = 1'b1;
      req = (dbl && i == 3);
      @(negedge clk);
    end
    req = 1'b0;
    vlow = 1'b0;
    chk(endk == kind, "R7 R8 outcome", endk, kind);
    for (int i = 0; i < ln; i++) begin
      chk(la[i][5:4] == 2'(exp_slot), "R5 slot", la[i][5:4], exp_slot);
      chk(la[i][3:0] == 4'(i), "R1 order", la[i][3:0], i);
      if (la[i][3:0] == 4'(MRK)) chk(kind == 0, "R7 marker withheld", la[i], 0);
    end
    if (kind == 0) begin
      chk(ln == P + 3, "R1 word count", ln, P + 3);
      for (int k = 0; k < P; k++) chk(ld[k] == pl[k*DW +: DW], "R1 payload", ld[k], pl[k*DW +: DW]);
      chk(ld[P] == crc_ref(pl), "R2 crc", ld[P], crc_ref(pl));
      chk(ld[P+1] == 16'(exp_seq), "R3 sequence", ld[P+1], exp_seq);
      chk(ld[MRK] == MARK, "R1 marker", ld[MRK], MARK);
      exp_seq++;
    end
    if (kind == 2) chk(we_cyc == TMO, "R8 timeout length", we_cyc, TMO);
    exp_slot = (exp_slot + 1) % SLOTS;
    n_before = ln;
    @(negedge clk);
    chk(done === 1'b0 && abrt === 1'b0 && terr === 1'b0, "R4 single pulse", {done, abrt, terr}, 0);
    if (dbl) begin
      repeat (4) @(negedge clk);
      chk(we === 1'b0 && busy === 1'b0 && ln == n_before, "R9 request while busy", {we, busy}, 0);
    end
  endtask

  initial begin
    bit seen_we;
    void'($urandom(32'h5EED1234));
    rst = 1'b1; req = 1'b0; vlow = 1'b0; rec = '0;
    repeat (4) @(negedge clk);
    chk(we === 1'b0 && busy === 1'b0 && done === 1'b0 && fs === 1'b0 &&
        abrt === 1'b0 && terr === 1'b0, "R10 reset state", {we, busy, done, fs, abrt, terr}, 0);
    rst = 1'b0;
    @(negedge clk);

    rdy_mode = 2;
    run_rec(0, -1, 1'b0);
    rdy_mode = 0;
    for (int n = 0; n < 10; n++) begin
      run_rec(0, -1, 1'b0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    run_rec(0, -1, 1'b1);

    // R7: low voltage while the marker waits on ready
    rdy_mode = 3;
    run_rec(1, P + 2, 1'b0);
    // R7: low voltage in the middle of the payload
    rdy_mode = 0;
    run_rec(1, 3, 1'b0);
    // R8: storage never ready
    rdy_mode = 1;
    run_rec(2, -1, 1'b0);
    rdy_mode = 0;

    // R9: request while voltage is low is ignored
    vlow = 1'b1;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    seen_we = 1'b0;
    repeat (6) begin
      if (we || busy) seen_we = 1'b1;
      @(negedge clk);
    end
    vlow = 1'b0;
    chk(!seen_we, "R9 request under low voltage", seen_we, 0);

    // R3 and R5: sequence resumes, slots keep wrapping
    for (int n = 0; n < 8; n++) run_rec(0, -1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule